// File: doc/BRIEF.md
# Address-Stable Automatic Sleep for a Memory Read Path

This block sits on the read path of a parallel memory and puts the read path into a low-power hold state on its own. Every clock it compares the address bus with the address it saw on the previous clock. When the address has stayed the same for a set number of clocks, it raises a sleep flag. That number is the access time plus a fixed margin, both given as clock counts.

The data output is a latch that is loaded exactly once per access. The load happens when the access-time count expires for the current address. The latched value then stays on the output for as long as the address is held, through sleep and beyond. A new address clears sleep at the next clock edge and starts a new access. The output keeps the old value until the new access completes.

Chip enable and output enable take no part in entering or leaving sleep. They only form the read-drive indication that tells the pad logic when to drive the bus.

Top module: `asl_auto_sleep`

## Requirements
- R1: With parameters ACC_CYC and MARGIN_CYC, let N be the number of rising edges counted from the first edge that sees a new address, that edge included. `sleep_o` is 0 while N ≤ ACC_CYC+MARGIN_CYC and 1 once N ≥ ACC_CYC+MARGIN_CYC+1, as long as the address does not change again.
- R2: `ce_n` and `oe_n` have no effect on `sleep_o`, on the stability count or on `data_o`.
- R3: While `sleep_o` is 1 and the address is unchanged, `data_o` does not change.
- R4: The first rising edge at which `addr_i` differs from the previously sampled address clears `sleep_o`.
- R5: A change of address restarts the stability count from zero at that edge. A count already in progress is discarded, so a later load needs a full ACC_CYC+1 edges on the new address.
- R6: After a change of address, `data_o` keeps its previous value while N ≤ ACC_CYC. When N = ACC_CYC+1 it takes the value of `arr_data_i` presented at that edge.
- R7: The stability count saturates, so `sleep_o` stays 1 indefinitely while the address is held.
- R8: Reset is synchronous and active low. At a rising edge with `rst_n` = 0, `sleep_o` becomes 0, `data_o` becomes 0, the count becomes 0 and the sampled address becomes 0.
- R9: `drive_o` is 1 exactly when both `ce_n` and `oe_n` are 0, whatever the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Read address bus |
| ce_n | input | 1 | Chip enable, active low (read drive only) |
| oe_n | input | 1 | Output enable, active low (read drive only) |
| arr_data_i | input | DW | Data from the memory array for `addr_i` |
| data_o | output | DW | Latched read data |
| sleep_o | output | 1 | Automatic sleep indication |
| drive_o | output | 1 | Read-drive indication for the bus pads |

## Verification
The bench works on the exact edge counts at which the data load and sleep entry happen, one hold short of each and one hold exactly on each. A design off by one in either direction would show data or sleep one clock early or late. A hold on one address that is too short, followed by a short hold on another, catches a counter that carries on instead of restarting: it would load the second address too early. Long holds with the enables toggled, a wake from sleep and a reset taken while asleep expose several faults. These are a counter that wraps and drops sleep, enables that leak into the sleep logic, a latch that follows the array while asleep or reloads too soon after waking, and a reset that leaves the latch or flag set.

// File: rtl/asl_pkg.sv
// Package: shared types and helpers for the address-stable auto-sleep block.
// Assumes nothing beyond elaboration-time constant evaluation.
package asl_pkg;

    // Status the stability counter hands to the data latch and the top.
    typedef struct packed {
        logic load;    // access-time count expires on this edge
        logic asleep;  // count has reached its terminal value
    } cnt_stat_t;

    // Bits needed to hold a count from 0 up to maxv inclusive.
    function automatic int cnt_w(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/asl_addr_watch.sv
// Address watcher: samples the address bus each clock and flags any
// difference between the live bus and the previous sample.
// Assumes the address is synchronous to clk.
module asl_addr_watch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    output logic          chg_o
);

    logic [AW-1:0] addr_q;

    // Keep the previous address sample; reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_i;
    end

    // Change flag seen by the edge that is about to sample.
    always_comb chg_o = (addr_i != addr_q);

endmodule

// File: rtl/asl_stable_cnt.sv
// Stability counter: counts clocks of unchanged address, restarts on a
// change, saturates at access time plus margin. Reports the load edge
// (count ACC_CYC-1 -> ACC_CYC) and the asleep state.
// Assumes ACC_CYC >= 1 and MARGIN_CYC >= 1.
module asl_stable_cnt
    import asl_pkg::*;
#(
    parameter int ACC_CYC    = 7,
    parameter int MARGIN_CYC = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      chg_i,
    output cnt_stat_t stat_o
);

    localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;
    localparam int CW        = cnt_w(SLEEP_CYC);
    localparam logic [CW-1:0] TERM  = CW'(SLEEP_CYC);
    localparam logic [CW-1:0] LDPRE = CW'(ACC_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Restart on change, otherwise count up to the terminal value and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (chg_i)         cnt_q <= '0;
        else if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
    end

    // Decode the load edge and the asleep state.
    always_comb begin
        stat_o.load   = !chg_i && (cnt_q == LDPRE);
        stat_o.asleep = (cnt_q == TERM);
    end

    // R5: a change always leaves the count at zero on the next cycle.
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (cnt_q == '0));

    // R7: once at the terminal value with a steady address, it stays there.
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o.asleep && !chg_i) |=> stat_o.asleep);

    // R1: one clock before the terminal value, a steady address enters sleep.
    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == CW'(SLEEP_CYC - 1)) && !chg_i) |=> stat_o.asleep);

endmodule

// File: rtl/asl_data_hold.sv
// Data latch: captures the array data on the load edge, lane by lane,
// and holds it at every other edge. Assumes DW is a multiple of LANE_W.
module asl_data_hold #(
    parameter int DW     = 16,
    parameter int LANE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o
);

    localparam int NLANE = DW / LANE_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Capture this lane on the load edge only; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      lane_q <= '0;
            else if (load_i) lane_q <= data_i[g*LANE_W +: LANE_W];
        end

        assign data_o[g*LANE_W +: LANE_W] = lane_q;
    end

    // R3/R6: without a load edge the latched output never moves.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_o));

endmodule

// File: rtl/asl_auto_sleep.sv
// Top: automatic sleep for a parallel memory read path. Sleep follows
// only from address stability; enables only form the read-drive flag.
// Assumes synchronous address and array data.
module asl_auto_sleep
    import asl_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int LANE_W     = 8,
    parameter int ACC_CYC    = 7,
    parameter int MARGIN_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [DW-1:0] arr_data_i,
    output logic [DW-1:0] data_o,
    output logic          sleep_o,
    output logic          drive_o
);

    logic      chg;
    cnt_stat_t stat;

    asl_addr_watch #(.AW(AW)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .chg_o  (chg)
    );

    asl_stable_cnt #(.ACC_CYC(ACC_CYC), .MARGIN_CYC(MARGIN_CYC)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg),
        .stat_o (stat)
    );

    asl_data_hold #(.DW(DW), .LANE_W(LANE_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (stat.load),
        .data_i (arr_data_i),
        .data_o (data_o)
    );

    // Sleep flag and pad drive; enables never reach the sleep path.
    always_comb begin
        sleep_o = stat.asleep;
        drive_o = !ce_n && !oe_n;
    end

    // R4: an address change seen at an edge leaves sleep low afterwards.
    p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !sleep_o);

    // R3: asleep with a steady address keeps the output latched.
    p_sleep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !chg) |=> $stable(data_o));

endmodule

// File: tb/asl_auto_sleep_test.sv
`timescale 1ns/1ps
module asl_auto_sleep_test;

    localparam int AW = 8, DW = 16, ACC = 7, MRG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] arr_data, data_o;
    logic          sleep_o, drive_o;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    // Array model: fixed content per address.
    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {a, a ^ 8'hA5};
    endfunction
    assign arr_data = memf(addr);

    asl_auto_sleep #(.AW(AW), .DW(DW), .LANE_W(8), .ACC_CYC(ACC), .MARGIN_CYC(MRG)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce_n(ce_n), .oe_n(oe_n),
        .arr_data_i(arr_data), .data_o(data_o), .sleep_o(sleep_o), .drive_o(drive_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Vector: address, edges held, {ce_n,oe_n}, expected sleep, address whose data is expected.
    typedef struct packed {
        logic [7:0]  a;
        logic [15:0] n;
        logic [1:0]  ctl;
        logic        sl;
        logic [7:0]  da;
    } vec_t;

    // Load at N = ACC+1 = 8, sleep at N = ACC+MRG+1 = 11.
    localparam vec_t VECS [0:9] = '{
        '{8'h11, 16'd20,  2'b00, 1'b1, 8'h11},  // R1 R6 long hold
        '{8'h22, 16'd3,   2'b01, 1'b0, 8'h11},  // R4 wake, R6 old data held
        '{8'h33, 16'd8,   2'b10, 1'b0, 8'h33},  // R6 load boundary
        '{8'h44, 16'd7,   2'b11, 1'b0, 8'h33},  // R6 one short of load
        '{8'h45, 16'd2,   2'b00, 1'b0, 8'h33},  // R5 restart discards progress
        '{8'h55, 16'd10,  2'b00, 1'b0, 8'h55},  // R1 one short of sleep
        '{8'h66, 16'd11,  2'b01, 1'b1, 8'h66},  // R1 sleep boundary
        '{8'h77, 16'd200, 2'b10, 1'b1, 8'h77},  // R7 saturation
        '{8'h78, 16'd11,  2'b11, 1'b1, 8'h78},  // R2 enables off, still sleeps
        '{8'h79, 16'd5,   2'b10, 1'b0, 8'h78}   // R6 hold after wake
    };

    initial begin
        // R8: reset state
        addr = 8'h5A;
        @(negedge clk);
        edges(2);
        chk("R8 sleep", 32'(sleep_o), 32'd0);
        chk("R8 data", 32'(data_o), 32'd0);
        rst_n = 1'b1;
        addr = 8'h00;
        edges(2);

        foreach (VECS[i]) begin
            addr = VECS[i].a;
            {ce_n, oe_n} = VECS[i].ctl;
            edges(int'(VECS[i].n));
            chk("R1 sleep", 32'(sleep_o), 32'(VECS[i].sl));
            chk("R6 data", 32'(data_o), 32'(memf(VECS[i].da)));
            chk("R9 drive", 32'(drive_o), 32'(VECS[i].ctl == 2'b00));
        end

        // R2/R3: enables toggled while asleep
        edges(20);
        chk("R7 sleep", 32'(sleep_o), 32'd1);
        for (int k = 0; k < 10; k++) begin
            {ce_n, oe_n} = 2'(k);
            edges(1);
        end
        chk("R2 sleep", 32'(sleep_o), 32'd1);
        chk("R3 data", 32'(data_o), 32'(memf(8'h79)));

        // R4/R6: wake and reload timing
        addr = 8'h80;
        edges(1);
        chk("R4 sleep", 32'(sleep_o), 32'd0);
        chk("R6 data", 32'(data_o), 32'(memf(8'h79)));
        edges(6);
        chk("R6 data", 32'(data_o), 32'(memf(8'h79)));
        edges(1);
        chk("R6 data", 32'(data_o), 32'(memf(8'h80)));

        // R8: reset taken while asleep
        edges(20);
        chk("R1 sleep", 32'(sleep_o), 32'd1);
        rst_n = 1'b0;
        edges(1);
        chk("R8 sleep", 32'(sleep_o), 32'd0);
        chk("R8 data", 32'(data_o), 32'd0);
        rst_n = 1'b1;
        edges(11);
        chk("R1 sleep", 32'(sleep_o), 32'd1);
        chk("R6 data", 32'(data_o), 32'(memf(8'h80)));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule